// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32.768 kHz tick strobe into periodic interrupt events and square-wave pulses. The tick strobe is one clock wide and arrives in the fast system clock domain. A 4-bit rate code selects a power-of-two period between 4 and 16384 ticks. Two enables gate the outputs independently. One enables the interrupt event, which also asks the status register to set its periodic and master flags. The other enables the square-wave pulse.

Every event falls on a multiple of the period in a 15-bit tick count. That count starts at zero on reset and runs freely. Because of this, a new rate code takes effect at the next boundary of the new period, counted from the same count. If a tick arrives in the cycle where the code changes, that tick produces no event. This keeps a half-applied code from causing a stray event.

Top module: `periodic_irq_divider`

## Requirements
- R1: A rate code of 0 produces no interrupt event and no square-wave pulse, whatever the enables.
- R2: For rate codes 3 to 15 the period is 2^(code-1) ticks: code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R3: Rate codes 1 and 2 behave like codes 8 and 9, giving periods of 128 and 256 ticks.
- R4: Events occur exactly on the ticks that bring the 15-bit tick count since reset to a multiple of the period. The count wraps from 32767 to 0, and 0 is a boundary.
- R5: `periodic_evt` pulses on an event only while `pie_en` is 1. In the same cycle `flag_set` is 8'hC0 (bit 7 is the master interrupt flag, bit 6 is the periodic flag). At all other times `flag_set` is 8'h00.
- R6: `sqw_pulse` pulses on an event only while `sqw_en` is 1. With both enables at 0 the block emits nothing.
- R7: Outputs are registered. They appear in the cycle after the clock edge that samples the tick and last exactly one cycle.
- R8: A tick sampled in a cycle whose rate code differs from the previous cycle's code produces no event. Later events follow the new period's boundaries on the same tick count.
- R9: A synchronous active-high reset clears the tick count and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz tick |
| rate_code | input | 4 | Period select code, 0 = off |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| periodic_evt | output | 1 | One-cycle periodic interrupt event |
| flag_set | output | 8 | Status flag set mask, 8'hC0 on an interrupt event |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The bench builds the block with its default parameters: a 15-bit tick count, a 4-bit code, and codes 1 and 2 remapped by adding 7. These values keep the full range within reach, from the 4-tick period to the 16384-tick period. Ticking every clock cycle also lets a full 32768-tick wrap of the count finish in a short run. A table of code and enable settings is walked with the event counts expected from the tick count. Directed cases then cover a code change between ticks, a code change on the same cycle as a shared boundary tick, a reset in the middle of a run, and the wrap of the count.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int PID_CNT_W        = 15;
    localparam int PID_CODE_W       = 4;
    localparam int PID_REMAP_LIMIT  = 2;
    localparam int PID_REMAP_ADD    = 7;
    localparam int PID_FLAG_W       = 8;
    localparam int PID_FLAG_PF_BIT  = 6;
    localparam int PID_FLAG_IRQ_BIT = 7;

    typedef struct packed {
        logic periodic;
        logic square;
    } pid_out_t;

    function automatic logic [PID_FLAG_W-1:0] pid_flag_mask(input logic hit);
        logic [PID_FLAG_W-1:0] m;
        m = '0;
        m[PID_FLAG_PF_BIT]  = hit;
        m[PID_FLAG_IRQ_BIT] = hit;
        return m;
    endfunction

endpackage

// File: rtl/pid_rate_decode.sv
module pid_rate_decode #(
    parameter int CODE_W      = 4,
    parameter int CNT_W       = 15,
    parameter int REMAP_LIMIT = 2,
    parameter int REMAP_ADD   = 7
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [CNT_W-1:0]  mask_o
);
    localparam int EFF_W = CODE_W + 1;

    logic [EFF_W-1:0] eff;

    always_comb begin
        if (code_i <= CODE_W'(REMAP_LIMIT))
            eff = {1'b0, code_i} + EFF_W'(REMAP_ADD);
        else
            eff = {1'b0, code_i};
    end

    assign valid_o = (code_i != '0);

    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask_o[g] = valid_o && ((g + 1) < int'(eff));
    end

endmodule

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_next_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_next_o;
    end

    // R4: the count advances by exactly one per tick, wrapping freely
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/pid_event_gen.sv
module pid_event_gen
    import pid_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CNT_W-1:0]  cnt_next_i,
    input  logic [CNT_W-1:0]  mask_i,
    input  logic              valid_i,
    input  logic              code_stable_i,
    input  logic              pie_en_i,
    input  logic              sqw_en_i,
    output pid_out_t          out_o,
    output logic [FLAG_W-1:0] flag_o
);
    logic     boundary;
    logic     fire;
    pid_out_t out_d;

    assign boundary = ((cnt_next_i & mask_i) == '0);
    assign fire     = tick_i && valid_i && code_stable_i && boundary;

    always_comb begin
        out_d.periodic = fire && pie_en_i;
        out_d.square   = fire && sqw_en_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o  <= '0;
            flag_o <= '0;
        end else begin
            out_o  <= out_d;
            flag_o <= pid_flag_mask(out_d.periodic);
        end
    end

    // R7: pulses never stretch past one cycle
    a_r7_evt_one_cycle: assert property (@(posedge clk) disable iff (rst)
        out_o.periodic |=> !out_o.periodic);

    a_r7_sqw_one_cycle: assert property (@(posedge clk) disable iff (rst)
        out_o.square |=> !out_o.square);

    // R7: every output pulse follows a sampled tick
    a_r7_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (out_o.periodic || out_o.square) |-> $past(tick_i));

endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import pid_pkg::*;
#(
    parameter int CNT_W       = PID_CNT_W,
    parameter int CODE_W      = PID_CODE_W,
    parameter int REMAP_LIMIT = PID_REMAP_LIMIT,
    parameter int REMAP_ADD   = PID_REMAP_ADD,
    parameter int FLAG_W      = PID_FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqw_en,
    output logic              periodic_evt,
    output logic [FLAG_W-1:0] flag_set,
    output logic              sqw_pulse
);
    logic [CODE_W-1:0] code_q;
    logic              code_stable;
    logic              rate_valid;
    logic [CNT_W-1:0]  rate_mask;
    logic [CNT_W-1:0]  cnt_next;
    pid_out_t          outs;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else
            code_q <= rate_code;
    end

    assign code_stable = (code_q == rate_code);

    pid_rate_decode #(
        .CODE_W      (CODE_W),
        .CNT_W       (CNT_W),
        .REMAP_LIMIT (REMAP_LIMIT),
        .REMAP_ADD   (REMAP_ADD)
    ) u_decode (
        .code_i  (rate_code),
        .valid_o (rate_valid),
        .mask_o  (rate_mask)
    );

    pid_tick_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_32k),
        .cnt_next_o (cnt_next)
    );

    pid_event_gen #(
        .CNT_W  (CNT_W),
        .FLAG_W (FLAG_W)
    ) u_event (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick_32k),
        .cnt_next_i    (cnt_next),
        .mask_i        (rate_mask),
        .valid_i       (rate_valid),
        .code_stable_i (code_stable),
        .pie_en_i      (pie_en),
        .sqw_en_i      (sqw_en),
        .out_o         (outs),
        .flag_o        (flag_set)
    );

    assign periodic_evt = outs.periodic;
    assign sqw_pulse    = outs.square;

    // R1: code zero keeps both outputs silent
    a_r1_zero_code_silent: assert property (@(posedge clk) disable iff (rst)
        (rate_code == '0) |=> (!periodic_evt && !sqw_pulse));

    // R5: interrupt event only under its enable, flags track the event
    a_r5_pie_gate: assert property (@(posedge clk) disable iff (rst)
        periodic_evt |-> $past(pie_en));

    a_r5_flags_with_evt: assert property (@(posedge clk) disable iff (rst)
        (flag_set != '0) |-> periodic_evt);

    // R6: square pulse only under its enable
    a_r6_sqw_gate: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse |-> $past(sqw_en));

    // R8: a code change on the sampling cycle suppresses the event
    a_r8_no_glitch: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_code) |=> (!periodic_evt && !sqw_pulse));

endmodule

// File: tb/periodic_irq_divider_tb.sv
module periodic_irq_divider_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       periodic_evt;
    logic [7:0] flag_set;
    logic       sqw_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    periodic_irq_divider u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick_32k     (tick_32k),
        .rate_code    (rate_code),
        .pie_en       (pie_en),
        .sqw_en       (sqw_en),
        .periodic_evt (periodic_evt),
        .flag_set     (flag_set),
        .sqw_pulse    (sqw_pulse)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [3:0]  code;
        logic        pie;
        logic        sqw;
        logic [15:0] nticks;
        logic [7:0]  n_evt;
        logic [7:0]  n_sqw;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b1, 1'b0, 16'd20,    8'd5, 8'd0},  // R2 code 3, interrupt only
        '{4'd3,  1'b0, 1'b1, 16'd20,    8'd0, 8'd5},  // R6 square only
        '{4'd1,  1'b1, 1'b1, 16'd512,   8'd4, 8'd4},  // R3 code 1 -> 128
        '{4'd2,  1'b1, 1'b1, 16'd512,   8'd2, 8'd2},  // R3 code 2 -> 256
        '{4'd0,  1'b1, 1'b1, 16'd100,   8'd0, 8'd0},  // R1 code 0 off
        '{4'd5,  1'b0, 1'b0, 16'd64,    8'd0, 8'd0},  // R6 both enables off
        '{4'd6,  1'b1, 1'b1, 16'd100,   8'd3, 8'd3},  // R2 code 6 -> 32
        '{4'd15, 1'b1, 1'b1, 16'd16384, 8'd1, 8'd1},  // R2 code 15 -> 16384
        '{4'd14, 1'b1, 1'b0, 16'd16384, 8'd2, 8'd0}   // R2 code 14 -> 8192
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock with (or without) a tick; samples outputs after the edge
    task automatic step(input bit t, output bit ev, output bit sq, output logic [7:0] fl);
        @(negedge clk);
        tick_32k = t;
        @(posedge clk);
        #1;
        ev = periodic_evt;
        sq = sqw_pulse;
        fl = flag_set;
        tick_32k = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        bit ev, sq;
        logic [7:0] fl;
        int ne, ns, badf;

        // R9: reset state
        @(negedge clk);
        rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b1;
        tick_32k = 1'b1;
        @(posedge clk); #1;
        check(periodic_evt == 1'b0 && sqw_pulse == 1'b0, "R9 reset evt/sqw",
              {periodic_evt, sqw_pulse}, 0);
        check(flag_set == 8'h00, "R9 reset flags", flag_set, 0);
        tick_32k = 1'b0;

        // table walk
        for (int v = 0; v < NV; v++) begin
            rate_code = VECS[v].code;
            pie_en    = VECS[v].pie;
            sqw_en    = VECS[v].sqw;
            do_reset();
            step(1'b0, ev, sq, fl);
            step(1'b0, ev, sq, fl);
            ne = 0; ns = 0; badf = 0;
            for (int k = 0; k < int'(VECS[v].nticks); k++) begin
                step(1'b1, ev, sq, fl);
                ne += int'(ev);
                ns += int'(sq);
                if (fl != (ev ? 8'hC0 : 8'h00)) badf++;
            end
            check(ne == int'(VECS[v].n_evt), "R1/R2/R3 event count", ne, int'(VECS[v].n_evt));
            check(ns == int'(VECS[v].n_sqw), "R6 square count", ns, int'(VECS[v].n_sqw));
            check(badf == 0, "R5 flag mask", badf, 0);
        end

        // R8: code change between ticks, new boundaries from same count
        rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b1;
        do_reset();
        step(1'b0, ev, sq, fl);
        step(1'b0, ev, sq, fl);
        for (int k = 1; k <= 6; k++) step(1'b1, ev, sq, fl);   // count 6
        @(negedge clk);
        rate_code = 4'd5;                                    // period 16
        step(1'b0, ev, sq, fl);
        ne = 0;
        for (int k = 7; k <= 15; k++) begin
            step(1'b1, ev, sq, fl);
            ne += int'(ev);
        end
        check(ne == 0, "R8 no event at old boundary 8", ne, 0);
        step(1'b1, ev, sq, fl);                              // count 16
        check(ev == 1'b1, "R8 event at new boundary 16", ev, 1);
        // R7: gone the next cycle
        step(1'b0, ev, sq, fl);
        check(ev == 1'b0 && sq == 1'b0, "R7 single cycle pulse", {ev, sq}, 0);

        // R8: code changes on the same cycle as a shared-boundary tick
        for (int k = 17; k <= 31; k++) step(1'b1, ev, sq, fl);
        @(negedge clk);
        rate_code = 4'd3;
        tick_32k = 1'b1;                                     // count 32
        @(posedge clk); #1;
        check(periodic_evt == 1'b0 && sqw_pulse == 1'b0, "R8 glitch tick suppressed",
              {periodic_evt, sqw_pulse}, 0);
        tick_32k = 1'b0;
        ne = 0;
        for (int k = 33; k <= 35; k++) begin
            step(1'b1, ev, sq, fl);
            ne += int'(ev);
        end
        step(1'b1, ev, sq, fl);                              // count 36
        check(ne == 0 && ev == 1'b1, "R8 resumes at boundary 36", {ne[0], ev}, 1);

        // R9: reset in the middle of a run clears the count
        rate_code = 4'd3;
        do_reset();
        step(1'b0, ev, sq, fl);
        for (int k = 0; k < 2; k++) step(1'b1, ev, sq, fl);
        do_reset();
        step(1'b0, ev, sq, fl);
        ne = 0;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, ev, sq, fl);
            ne += int'(ev);
        end
        check(ne == 0, "R9 count cleared, no early event", ne, 0);
        step(1'b1, ev, sq, fl);
        check(ev == 1'b1, "R9 first event at fourth tick", ev, 1);

        // R4: full wrap of the 15-bit count with code 15
        rate_code = 4'd15;
        do_reset();
        step(1'b0, ev, sq, fl);
        step(1'b0, ev, sq, fl);
        ne = 0;
        for (int k = 1; k <= 32767; k++) begin
            step(1'b1, ev, sq, fl);
            ne += int'(ev);
        end
        check(ne == 1, "R4 one event before wrap", ne, 1);
        step(1'b1, ev, sq, fl);                              // count wraps to 0
        check(ev == 1'b1 && sq == 1'b1, "R4 event at wrap to zero", {ev, sq}, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule